// File: doc/BRIEF.md
# Sync-Gated Receive Bit FIFO

This block buffers a recovered serial bit stream for a host. Each received bit arrives on `bit_in` together with a one-cycle `bit_stb` strobe, and a bit only counts when the `data_valid` qualifier is high at that strobe. A bit that counts is stored only while filling is enabled and the stream has been qualified. Qualification comes in one of two ways. In sync mode, a pattern detector must first see a programmable synchronisation word in the most recent bits. In always-fill mode, no pattern is needed. The bits of the sync word are never stored.

Storage holds 16 bits in first-in, first-out order. The block reports its fill count, an empty flag, a sticky overflow flag and a level flag driven by a programmable threshold. The host drains the buffer in one of two ways. It can pop one bit at a time, where the oldest bit is always visible on `ser_bit`. It can also issue a byte read, which removes up to eight bits and returns them in one register. Clearing the fill enable stops storage and discards the search state, so setting it again starts a fresh pattern hunt. The sync low byte is normally programmed to D4h.

Top module: `sgf_top`

## Requirements
- R1: After reset `fill_count` is 0, `fifo_empty` is 1, and `overflow`, `level_flag`, `byte_valid` and `ser_bit` are 0. The buffer holds at most 16 bits, and `fifo_empty` is high exactly when the count is 0.
- R2: With `cfg_long_sync`=0 and `cfg_fill_always`=0, the detector compares the last 8 accepted bits with `cfg_sync_lo`. The oldest of those bits is compared with bit 7. The bits of the match are not stored. Storage begins with the next accepted bit.
- R3: With `cfg_long_sync`=1, the detector compares the last 16 accepted bits with the word {8'h2D, `cfg_sync_lo`}, oldest bit first. A match of the low byte alone does not start storage.
- R4: With `cfg_fill_always`=1 and `cfg_fill_en`=1, every accepted bit is stored without any pattern search.
- R5: A strobe with `data_valid`=0 is ignored by both the pattern search and the storage.
- R6: While `cfg_fill_en`=0, no bit is stored and the search state is cleared. After `cfg_fill_en` is set again, a new sync match is needed before storage resumes.
- R7: `level_flag` is high when the count is at least `cfg_level`. A threshold of 0 is treated as 1.
- R8: A bit that arrives while the count is 16, in a cycle that removes no bit, is dropped and sets `overflow`. The flag stays set until a cycle with `ovf_clr` high, and a new overflow in that same cycle wins.
- R9: `ser_bit` shows the oldest stored bit, or 0 when the buffer is empty. A `ser_pop` pulse removes that bit.
- R10: A `byte_rd` pulse removes min(count, 8) bits. The next cycle presents them on `byte_out` with the oldest bit in bit 7 and zeros below the last valid bit, and `byte_valid` pulses. If `byte_rd` and `ser_pop` are both high, `byte_rd` wins and `ser_pop` is ignored.
- R11: A read of an empty buffer returns 0 on `byte_out` or `ser_bit` and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Recovered data bit |
| bit_stb | input | 1 | One-cycle strobe marking a new bit |
| data_valid | input | 1 | Valid-data qualifier for the bit stream |
| cfg_fill_en | input | 1 | Fill enable; falling clears search, rising restarts it |
| cfg_fill_always | input | 1 | 1: store without sync search |
| cfg_long_sync | input | 1 | 1: 16-bit sync word, 0: low byte only |
| cfg_sync_lo | input | 8 | Programmable sync low byte |
| cfg_level | input | 4 | Level-flag threshold |
| ovf_clr | input | 1 | Clears the overflow flag |
| ser_pop | input | 1 | Remove the oldest bit |
| byte_rd | input | 1 | Remove up to eight bits as one byte |
| ser_bit | output | 1 | Oldest stored bit (0 if empty) |
| byte_out | output | 8 | Result of the last byte read |
| byte_valid | output | 1 | Pulses the cycle after a byte read |
| fill_count | output | 5 | Number of stored bits |
| level_flag | output | 1 | Count has reached the threshold |
| fifo_empty | output | 1 | No bits stored |
| overflow | output | 1 | Sticky overflow flag |

## Verification
An accepted bit appears in `fill_count`, `fifo_empty`, `level_flag` and `overflow` one cycle after the strobe edge. The lock happens on the edge that takes the last sync bit, so the next strobed bit is the first one stored. A byte read updates `byte_out`, `byte_valid` and the count one edge after the pulse, while `ser_bit` follows the head with no delay. The bench drives every input at the falling edge, holds it across exactly one rising edge, and samples at the following falling edge. Each expected value therefore falls in the first cycle where it becomes due.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

    localparam int SYNC_BYTE_W = 8;
    localparam int SYNC_SR_W   = 2 * SYNC_BYTE_W;
    localparam int SEEN_W      = $clog2(SYNC_SR_W + 1);
    localparam logic [SYNC_BYTE_W-1:0] SYNC_HI_BYTE = 8'h2D;

    typedef struct packed {
        logic                   fill_en;
        logic                   fill_always;
        logic                   long_sync;
        logic [SYNC_BYTE_W-1:0] sync_lo;
    } fill_cfg_t;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_SERIAL = 2'd1,
        RD_BYTE   = 2'd2
    } rd_kind_t;

    function automatic logic pattern_hit(
        input logic [SYNC_SR_W-1:0]   window,
        input logic                   long_mode,
        input logic [SYNC_BYTE_W-1:0] lo_byte
    );
        if (long_mode)
            return window == {SYNC_HI_BYTE, lo_byte};
        return window[SYNC_BYTE_W-1:0] == lo_byte;
    endfunction

endpackage

// File: rtl/sgf_sync_gate.sv
module sgf_sync_gate
    import sgf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_in,
    input  logic      bit_acc,
    input  fill_cfg_t cfg,
    output logic      wr_en
);

    logic [SYNC_SR_W-1:0] shreg;
    logic [SEEN_W-1:0]    seen;
    logic                 locked;
    logic [SYNC_SR_W-1:0] window;
    logic [SEEN_W-1:0]    need_m1;
    logic                 searching;
    logic                 hit;

    always_comb begin
        window    = {shreg[SYNC_SR_W-2:0], bit_in};
        need_m1   = cfg.long_sync ? SEEN_W'(SYNC_SR_W - 1) : SEEN_W'(SYNC_BYTE_W - 1);
        searching = cfg.fill_en && !cfg.fill_always && !locked;
        hit       = searching && bit_acc && (seen >= need_m1)
                    && pattern_hit(window, cfg.long_sync, cfg.sync_lo);
        wr_en     = bit_acc && cfg.fill_en && (cfg.fill_always || locked);
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg.fill_en) begin
            shreg  <= '0;
            seen   <= '0;
            locked <= 1'b0;
        end else if (searching && bit_acc) begin
            shreg <= window;
            if (seen != SEEN_W'(SYNC_SR_W))
                seen <= seen + 1'b1;
            if (hit)
                locked <= 1'b1;
        end
    end

    // R6: dropping the fill enable always abandons a lock
    assert_search_reset_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg.fill_en |=> !locked);

    // R2: a lock can only be taken on an accepted bit
    assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(bit_acc));

    // R5: an unqualified strobe never advances the search
    assert_ignore_invalid_R5: assert property (@(posedge clk) disable iff (rst)
        (!bit_acc && cfg.fill_en) |=> $stable(seen));

endmodule

// File: rtl/sgf_bit_store.sv
module sgf_bit_store #(
    parameter  int DEPTH  = 16,
    parameter  int BYTE_W = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int POP_W  = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [POP_W-1:0]  pop_n,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] peek,
    output logic              ovf_evt
);

    // DEPTH is a power of two so that pointers wrap naturally
    logic [DEPTH-1:0] mem;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic             full;
    logic             accept;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_peek
        assign peek[i] = mem[PTR_W'(rd_ptr + PTR_W'(i))];
    end

    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        accept  = wr_en && (!full || (pop_n != '0));
        ovf_evt = wr_en && full && (pop_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem    <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) begin
                mem[wr_ptr] <= wr_bit;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            rd_ptr <= PTR_W'(rd_ptr + PTR_W'(pop_n));
            count  <= count - CNT_W'(pop_n) + CNT_W'(accept);
        end
    end

    // R1: the stored count never exceeds the capacity
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R11: the read side never removes more than is stored
    assert_pop_limit_R11: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(pop_n) <= count);

    // R8: a rejected write leaves the buffer full
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/sgf_read_port.sv
module sgf_read_port
    import sgf_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int BYTE_W = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int POP_W  = $clog2(BYTE_W + 1)
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [BYTE_W-1:0] peek,
    input  logic              ser_pop,
    input  logic              byte_rd,
    output logic [POP_W-1:0]  pop_n,
    output logic [BYTE_W-1:0] byte_next,
    output logic              ser_bit
);

    logic [POP_W-1:0] avail;
    rd_kind_t         kind;

    always_comb begin
        avail = (count >= CNT_W'(BYTE_W)) ? POP_W'(BYTE_W) : POP_W'(count);
        if (byte_rd)
            kind = RD_BYTE;
        else if (ser_pop && (count != '0))
            kind = RD_SERIAL;
        else
            kind = RD_IDLE;
        unique case (kind)
            RD_BYTE:   pop_n = avail;
            RD_SERIAL: pop_n = POP_W'(1);
            default:   pop_n = '0;
        endcase
        ser_bit = (count != '0) ? peek[0] : 1'b0;
    end

    // oldest bit goes to the top, missing bits read as zero
    for (genvar i = 0; i < BYTE_W; i++) begin : g_pack
        assign byte_next[BYTE_W-1-i] = (POP_W'(i) < avail) ? peek[i] : 1'b0;
    end

endmodule

// File: rtl/sgf_top.sv
module sgf_top
    import sgf_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int BYTE_W = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LVL_W  = $clog2(DEPTH),
    localparam int POP_W  = $clog2(BYTE_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_in,
    input  logic                   bit_stb,
    input  logic                   data_valid,
    input  logic                   cfg_fill_en,
    input  logic                   cfg_fill_always,
    input  logic                   cfg_long_sync,
    input  logic [SYNC_BYTE_W-1:0] cfg_sync_lo,
    input  logic [LVL_W-1:0]       cfg_level,
    input  logic                   ovf_clr,
    input  logic                   ser_pop,
    input  logic                   byte_rd,
    output logic                   ser_bit,
    output logic [BYTE_W-1:0]      byte_out,
    output logic                   byte_valid,
    output logic [CNT_W-1:0]       fill_count,
    output logic                   level_flag,
    output logic                   fifo_empty,
    output logic                   overflow
);

    fill_cfg_t         cfg;
    logic              bit_acc;
    logic              wr_en;
    logic [POP_W-1:0]  pop_n;
    logic [BYTE_W-1:0] peek;
    logic [BYTE_W-1:0] byte_next;
    logic              ovf_evt;
    logic [CNT_W-1:0]  thr;

    always_comb begin
        cfg.fill_en     = cfg_fill_en;
        cfg.fill_always = cfg_fill_always;
        cfg.long_sync   = cfg_long_sync;
        cfg.sync_lo     = cfg_sync_lo;
        bit_acc         = bit_stb && data_valid;
    end

    sgf_sync_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_acc (bit_acc),
        .cfg     (cfg),
        .wr_en   (wr_en)
    );

    sgf_bit_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bit  (bit_in),
        .pop_n   (pop_n),
        .count   (fill_count),
        .peek    (peek),
        .ovf_evt (ovf_evt)
    );

    sgf_read_port #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_read (
        .count     (fill_count),
        .peek      (peek),
        .ser_pop   (ser_pop),
        .byte_rd   (byte_rd),
        .pop_n     (pop_n),
        .byte_next (byte_next),
        .ser_bit   (ser_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_out   <= '0;
            byte_valid <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            byte_valid <= byte_rd;
            if (byte_rd)
                byte_out <= byte_next;
            if (ovf_evt)
                overflow <= 1'b1;
            else if (ovf_clr)
                overflow <= 1'b0;
        end
    end

    always_comb begin
        thr        = (cfg_level == '0) ? CNT_W'(1) : CNT_W'(cfg_level);
        level_flag = (fill_count >= thr);
        fifo_empty = (fill_count == '0);
    end

    // R6: with filling off and no reads, the count holds
    assert_fill_off_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_fill_en && !ser_pop && !byte_rd) |=> $stable(fill_count));

    // R11: reading an empty buffer without a new bit keeps it empty
    assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && !bit_stb) |=> fifo_empty);

    // R8: overflow is sticky until cleared
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);

    // R7: the level flag never claims data in an empty buffer
    assert_level_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
        level_flag |-> !fifo_empty);

    // R10: every byte read is answered on the next cycle
    assert_byte_valid_R10: assert property (@(posedge clk) disable iff (rst)
        byte_rd |=> byte_valid);

endmodule

// File: tb/tb_sgf_top.sv
module tb_sgf_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        long_m;
        logic        always_m;
        logic [7:0]  lo;
        logic [23:0] stream;
        logic [4:0]  nbits;
        logic [4:0]  exp_cnt;
        logic [7:0]  exp_byte;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 8'hD4, 24'hD4A500, 5'd16, 5'd8, 8'hA5},  // R2
        '{1'b1, 1'b0, 8'hD4, 24'h2DD43C, 5'd24, 5'd8, 8'h3C},  // R3
        '{1'b0, 1'b1, 8'hD4, 24'h810000, 5'd8,  5'd8, 8'h81},  // R4
        '{1'b0, 1'b0, 8'hD4, 24'h00FF00, 5'd16, 5'd0, 8'h00},  // R2 no match
        '{1'b1, 1'b0, 8'hD4, 24'hD47700, 5'd16, 5'd0, 8'h00},  // R3 low byte alone
        '{1'b0, 1'b0, 8'hA7, 24'hFFA7C3, 5'd24, 5'd8, 8'hC3}   // R2 custom byte
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0, bit_stb = 1'b0, data_valid = 1'b0;
    logic       cfg_fill_en = 1'b0, cfg_fill_always = 1'b0, cfg_long_sync = 1'b0;
    logic [7:0] cfg_sync_lo = 8'hD4;
    logic [3:0] cfg_level = 4'd1;
    logic       ovf_clr = 1'b0, ser_pop = 1'b0, byte_rd = 1'b0;
    logic       ser_bit;
    logic [7:0] byte_out;
    logic       byte_valid;
    logic [4:0] fill_count;
    logic       level_flag, fifo_empty, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgf_top dut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_stb(bit_stb), .data_valid(data_valid),
        .cfg_fill_en(cfg_fill_en), .cfg_fill_always(cfg_fill_always),
        .cfg_long_sync(cfg_long_sync), .cfg_sync_lo(cfg_sync_lo), .cfg_level(cfg_level),
        .ovf_clr(ovf_clr), .ser_pop(ser_pop), .byte_rd(byte_rd), .ser_bit(ser_bit),
        .byte_out(byte_out), .byte_valid(byte_valid), .fill_count(fill_count),
        .level_flag(level_flag), .fifo_empty(fifo_empty), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_fill_en = 1'b0; cfg_fill_always = 1'b0; cfg_long_sync = 1'b0;
        cfg_sync_lo = 8'hD4; cfg_level = 4'd1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic send_bit(input logic b, input logic v);
        bit_in = b; bit_stb = 1'b1; data_valid = v;
        @(negedge clk);
        bit_stb = 1'b0; data_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) send_bit(d[i], 1'b1);
    endtask

    task automatic read_byte();
        byte_rd = 1'b1;
        @(negedge clk);
        byte_rd = 1'b0;
    endtask

    task automatic pop_bit();
        ser_pop = 1'b1;
        @(negedge clk);
        ser_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 count", fill_count, 0);
        chk("R1 empty", fifo_empty, 1);
        chk("R1 overflow", overflow, 0);
        chk("R1 level", level_flag, 0);
        chk("R1 byte_valid", byte_valid, 0);
        chk("R1 ser_bit", ser_bit, 0);

        // table walk: R2 R3 R4
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            cfg_long_sync = VECS[v].long_m;
            cfg_fill_always = VECS[v].always_m;
            cfg_sync_lo = VECS[v].lo;
            cfg_fill_en = 1'b1;
            for (int i = 0; i < int'(VECS[v].nbits); i++) send_bit(VECS[v].stream[23-i], 1'b1);
            chk($sformatf("R2/R3/R4 vec%0d count", v), fill_count, int'(VECS[v].exp_cnt));
            read_byte();
            chk($sformatf("R2/R3/R4 vec%0d byte", v), byte_out, int'(VECS[v].exp_byte));
        end

        // R5: unqualified strobes ignored in always mode and in sync search
        do_reset();
        cfg_fill_always = 1'b1; cfg_fill_en = 1'b1;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        chk("R5 always mode count", fill_count, 0);
        do_reset();
        cfg_fill_en = 1'b1;
        for (int i = 7; i >= 0; i--) send_bit(logic'((8'hD4 >> i) & 1), 1'b0);
        send_byte(8'h55);
        chk("R5 sync not seen", fill_count, 0);

        // R6: fill enable off stops storage, re-enable needs a new sync
        do_reset();
        cfg_fill_en = 1'b1;
        send_byte(8'hD4);
        chk("R2 sync bits not stored", fill_count, 0);
        send_bit(1, 1); send_bit(0, 1); send_bit(1, 1); send_bit(1, 1);
        chk("R6 before disable", fill_count, 4);
        cfg_fill_en = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1);
        chk("R6 disabled", fill_count, 4);
        cfg_fill_en = 1'b1;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1);
        chk("R6 re-enabled no sync", fill_count, 4);
        send_byte(8'hD4);
        chk("R6 new sync not stored", fill_count, 4);
        send_bit(0, 1); send_bit(0, 1); send_bit(1, 1); send_bit(1, 1);
        chk("R6 resumed", fill_count, 8);
        read_byte();
        chk("R6 byte", byte_out, 8'hB3);

        // R7: level flag
        do_reset();
        cfg_fill_always = 1'b1; cfg_fill_en = 1'b1; cfg_level = 4'd5;
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b1);
        chk("R7 below", level_flag, 0);
        send_bit(1'b1, 1'b1);
        chk("R7 reached", level_flag, 1);
        cfg_level = 4'd0;
        #1;
        chk("R7 zero as one", level_flag, 1);
        read_byte();
        chk("R10 partial byte", byte_out, 8'h08);
        chk("R7 empty zero thr", level_flag, 0);

        // R8 R1: overflow
        do_reset();
        cfg_fill_always = 1'b1; cfg_fill_en = 1'b1;
        send_byte(8'hC3); send_byte(8'hA5);
        chk("R1 full count", fill_count, 16);
        chk("R8 no overflow yet", overflow, 0);
        send_bit(1'b1, 1'b1);
        chk("R8 overflow set", overflow, 1);
        chk("R8 count held", fill_count, 16);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R8 cleared", overflow, 0);
        read_byte();
        chk("R8 first byte", byte_out, 8'hC3);
        read_byte();
        chk("R8 dropped bit", byte_out, 8'hA5);
        chk("R1 empty after drain", fifo_empty, 1);

        // R9 R11: serial pops
        do_reset();
        cfg_fill_always = 1'b1; cfg_fill_en = 1'b1;
        send_bit(1, 1); send_bit(0, 1); send_bit(1, 1);
        chk("R9 head 1", ser_bit, 1);
        pop_bit();
        chk("R9 head 2", ser_bit, 0);
        chk("R9 count", fill_count, 2);
        pop_bit();
        chk("R9 head 3", ser_bit, 1);
        pop_bit();
        chk("R9 empty", fifo_empty, 1);
        chk("R11 ser_bit zero", ser_bit, 0);
        pop_bit();
        chk("R11 pop empty count", fill_count, 0);
        read_byte();
        chk("R11 empty byte", byte_out, 0);
        chk("R11 byte_valid", byte_valid, 1);
        chk("R11 count", fill_count, 0);

        // R10: byte read wins over serial pop
        send_byte(8'hFF); send_bit(0, 1); send_bit(1, 1);
        byte_rd = 1'b1; ser_pop = 1'b1;
        @(negedge clk);
        byte_rd = 1'b0; ser_pop = 1'b0;
        chk("R10 priority count", fill_count, 2);
        chk("R10 byte", byte_out, 8'hFF);
        chk("R10 next head", ser_bit, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule